// File: doc/BRIEF.md
# Shared Ring Oscillator Random Bit and Fingerprint Engine

This block is the digital back end of a combined true random bit source and device fingerprint. A bank of free-running ring oscillators feeds two paths that work at the same time. The entropy path captures every ring output on the stable reference clock and passes it through two synchronizer stages. It then folds all rings into one bit with an XOR tree and registers that bit, so one random bit appears on every reference cycle. The fingerprint path takes a challenge that names two rings. It clears a pair of edge counters, lets them count over a programmable window of reference cycles, and brings the counts into the reference domain in Gray code. It then compares the two counts and returns a one-bit response.

The block also holds a configuration register for each ring. The register sets a 5-bit delay-select code, which tunes the ring's stage delay without changing its inversion, and a run enable that gates the ring's AND stage. The oscillator loops themselves sit outside this block and arrive on `ring_in`. Each ring is assumed to run faster than the reference clock whenever it is enabled.

Top module: `ring_rng_fingerprint`

## Requirements
- R1: While `rst_n` is low at a clock edge, all ring enables and delay codes clear to zero, and `busy`, `resp_valid`, `chal_err` and `rnd_valid` are low after that edge.
- R2: A cycle with `cfg_we` high writes `cfg_code` into `ring_dly[5*cfg_idx +: 5]` and `cfg_run` into `ring_en[cfg_idx]`. The change is visible after that edge, every other ring's fields stay unchanged, and no field changes without `cfg_we`.
- R3: `rnd_bit` equals the XOR of all `ring_in` lines as sampled three reference edges earlier (two synchronizer stages and an output register).
- R4: `rnd_valid` equals the OR of all `ring_en` bits as they stood three reference edges earlier.
- R5: A challenge carries the first ring index A in `chal[4:0]` and the second ring index B in `chal[9:5]`. `resp_bit` is 1 when the edge count of ring A over the window is larger than that of ring B, and 0 otherwise.
- R6: When the two counts are equal, `resp_bit` is 0 and `resp_tie` is 1. Otherwise `resp_tie` is 0.
- R7: A challenge with A equal to B starts no measurement. `chal_err` pulses high for one cycle after the accepting edge, `busy` stays low and no `resp_valid` follows.
- R8: An accepted challenge raises `busy` from the next cycle for exactly max(`win_len`,1)+8 cycles. `resp_valid` is high for the single cycle in which `busy` has just fallen, and `resp_bit` and `resp_tie` are valid in that cycle.
- R9: `chal_valid` while `busy` is high is ignored. The running measurement keeps its length and returns only its own response.
- R10: The random bit path keeps `rnd_valid` high on every cycle of a measurement while any ring is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stable reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_in | input | 32 | Ring oscillator outputs, one per ring |
| ring_en | output | 32 | Run enable for each ring |
| ring_dly | output | 160 | 5-bit delay-select code per ring, ring k at bits 5k+4..5k |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 5 | Ring addressed by the write |
| cfg_code | input | 5 | Delay code to write |
| cfg_run | input | 1 | Enable value to write |
| win_len | input | 16 | Count window in reference cycles |
| chal_valid | input | 1 | Challenge request |
| chal | input | 10 | Two ring indices, A low and B high |
| busy | output | 1 | Measurement in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_bit | output | 1 | Fingerprint response |
| resp_tie | output | 1 | Counts were equal |
| chal_err | output | 1 | One-cycle pulse for a rejected challenge |
| rnd_bit | output | 1 | Random bit |
| rnd_valid | output | 1 | Random bit qualifier |

## Verification
The bench holds the ring lines at chosen static patterns and shifts the pattern every cycle. A tree that missed a ring would then show the wrong parity, and a pipeline one stage short or long would show the parity of a neighbouring pattern. It compares a fast ring with a slow one in both orders, so a swapped index field or an inverted comparison flips the response. It also measures two rings of equal period, where a design that ignored equal counts would return no tie flag or a 1. It injects a challenge mid-window, sends one with equal indices, and uses a zero window. A controller that restarted, accepted a duplicate, or let the window count wrap would stretch `busy` or emit an unexpected response.

// File: rtl/rrf_pkg.sv
`timescale 1ns/1ps
// Shared types for the ring oscillator random bit and fingerprint engine.
package rrf_pkg;

    // Phases of one fingerprint measurement.
    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_CLEAR = 2'd1,
        MS_COUNT = 2'd2,
        MS_DRAIN = 2'd3
    } meas_state_t;

endpackage

// File: rtl/rrf_cfg_bank.sv
`timescale 1ns/1ps
// Per-ring configuration registers: a delay-select code and a run enable.
// Assumes one write per cycle, addressed by index; writes to indices at or
// beyond N_RING have no effect.
module rrf_cfg_bank #(
    parameter int N_RING = 32,
    parameter int CODE_W = 5,
    localparam int IDX_W = $clog2(N_RING)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [CODE_W-1:0]        wr_code,
    input  logic                     wr_run,
    output logic [N_RING-1:0]        run_en,
    output logic [N_RING*CODE_W-1:0] dly_code
);

    for (genvar g = 0; g < N_RING; g++) begin : g_ring
        logic [CODE_W-1:0] code_q;
        logic              run_q;

        // Hold or update this ring's code and enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q <= '0;
                run_q  <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                code_q <= wr_code;
                run_q  <= wr_run;
            end
        end

        assign dly_code[g*CODE_W +: CODE_W] = code_q;
        assign run_en[g]                    = run_q;
    end

endmodule

// File: rtl/rrf_entropy_path.sv
`timescale 1ns/1ps
// Random bit path: two synchronizer flops per ring, an XOR fold of all
// rings, and an output register. The valid strobe follows the OR of the
// ring enables through the same three register stages.
module rrf_entropy_path #(
    parameter int N_RING = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_RING-1:0] ring_in,
    input  logic [N_RING-1:0] run_en,
    output logic              rnd_bit,
    output logic              rnd_valid
);

    logic [N_RING-1:0] samp_s1;
    logic [N_RING-1:0] samp_s2;
    logic              fold;
    logic [1:0]        any_pipe;

    // Capture and resynchronize every ring output on the reference clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_s1 <= '0;
            samp_s2 <= '0;
        end else begin
            samp_s1 <= ring_in;
            samp_s2 <= samp_s1;
        end
    end

    // XOR tree over the synchronized samples.
    always_comb begin
        fold = 1'b0;
        for (int i = 0; i < N_RING; i++) begin
            fold = fold ^ samp_s2[i];
        end
    end

    // Register the folded bit and align the valid strobe with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rnd_bit   <= 1'b0;
            any_pipe  <= '0;
            rnd_valid <= 1'b0;
        end else begin
            rnd_bit   <= fold;
            any_pipe  <= {any_pipe[0], |run_en};
            rnd_valid <= any_pipe[1];
        end
    end

endmodule

// File: rtl/rrf_edge_counter.sv
`timescale 1ns/1ps
// Edge counter living in one ring's clock domain. The clear and run
// requests from the reference domain are synchronized on the ring clock;
// the count is published in Gray code and resynchronized back on the
// reference clock. Assumes the ring runs faster than the reference clock
// while it is measured. The count saturates at its maximum.
module rrf_edge_counter #(
    parameter int CNT_W = 20
) (
    input  logic             ring_clk,
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_req,
    input  logic             run_req,
    output logic [CNT_W-1:0] count
);

    logic [1:0]       ctl_s1;
    logic [1:0]       ctl_s2;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] gray_q;
    logic [CNT_W-1:0] gray_r1;
    logic [CNT_W-1:0] gray_r2;

    function automatic logic [CNT_W-1:0] gray_to_bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        b[CNT_W-1] = g[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Bring clear and run into the ring domain together.
    always_ff @(posedge ring_clk) begin
        if (!rst_n) begin
            ctl_s1 <= '0;
            ctl_s2 <= '0;
        end else begin
            ctl_s1 <= {clr_req, run_req};
            ctl_s2 <= ctl_s1;
        end
    end

    // Count ring edges while running, zero while cleared.
    always_ff @(posedge ring_clk) begin
        if (!rst_n || ctl_s2[1]) begin
            cnt_q <= '0;
        end else if (ctl_s2[0] && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Publish the count in Gray code so one bit moves per step.
    always_ff @(posedge ring_clk) begin
        if (!rst_n) begin
            gray_q <= '0;
        end else begin
            gray_q <= cnt_q ^ (cnt_q >> 1);
        end
    end

    // Resynchronize the Gray count on the reference clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gray_r1 <= '0;
            gray_r2 <= '0;
        end else begin
            gray_r1 <= gray_q;
            gray_r2 <= gray_r1;
        end
    end

    assign count = gray_to_bin(gray_r2);

endmodule

// File: rtl/rrf_measure_ctrl.sv
`timescale 1ns/1ps
// Fingerprint measurement sequencer. Accepts a challenge only when idle,
// rejects equal indices, then runs clear, count-window and drain phases
// and registers the comparison of the two counts. A zero window acts as
// one cycle. Clear and run are driven straight from flops.
module rrf_measure_ctrl
    import rrf_pkg::*;
#(
    parameter int IDX_W     = 5,
    parameter int WIN_W     = 16,
    parameter int CNT_W     = 20,
    parameter int CLR_CYC   = 4,
    parameter int DRAIN_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chal_valid,
    input  logic [2*IDX_W-1:0] chal,
    input  logic [WIN_W-1:0]   win_len,
    input  logic [CNT_W-1:0]   count_a,
    input  logic [CNT_W-1:0]   count_b,
    output logic [IDX_W-1:0]   sel_a,
    output logic [IDX_W-1:0]   sel_b,
    output logic               clr_req,
    output logic               run_req,
    output logic               busy,
    output logic               resp_valid,
    output logic               resp_bit,
    output logic               resp_tie,
    output logic               chal_err
);

    meas_state_t      state;
    logic [WIN_W-1:0] timer;
    logic [WIN_W:0]   timer_inc;
    logic [IDX_W-1:0] chal_a;
    logic [IDX_W-1:0] chal_b;

    assign chal_a    = chal[IDX_W-1:0];
    assign chal_b    = chal[2*IDX_W-1:IDX_W];
    assign timer_inc = {1'b0, timer} + {{WIN_W{1'b0}}, 1'b1};
    assign busy      = (state != MS_IDLE);

    // Sequence one measurement and produce the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= MS_IDLE;
            timer      <= '0;
            sel_a      <= '0;
            sel_b      <= '0;
            clr_req    <= 1'b0;
            run_req    <= 1'b0;
            resp_valid <= 1'b0;
            resp_bit   <= 1'b0;
            resp_tie   <= 1'b0;
            chal_err   <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            chal_err   <= 1'b0;
            case (state)
                MS_IDLE: begin
                    if (chal_valid) begin
                        if (chal_a == chal_b) begin
                            chal_err <= 1'b1;
                        end else begin
                            sel_a   <= chal_a;
                            sel_b   <= chal_b;
                            clr_req <= 1'b1;
                            timer   <= '0;
                            state   <= MS_CLEAR;
                        end
                    end
                end
                MS_CLEAR: begin
                    if (timer == WIN_W'(CLR_CYC - 1)) begin
                        clr_req <= 1'b0;
                        run_req <= 1'b1;
                        timer   <= '0;
                        state   <= MS_COUNT;
                    end else begin
                        timer <= timer_inc[WIN_W-1:0];
                    end
                end
                MS_COUNT: begin
                    if (timer_inc >= {1'b0, win_len}) begin
                        run_req <= 1'b0;
                        timer   <= '0;
                        state   <= MS_DRAIN;
                    end else begin
                        timer <= timer_inc[WIN_W-1:0];
                    end
                end
                MS_DRAIN: begin
                    if (timer == WIN_W'(DRAIN_CYC - 1)) begin
                        resp_valid <= 1'b1;
                        resp_bit   <= (count_a > count_b);
                        resp_tie   <= (count_a == count_b);
                        timer      <= '0;
                        state      <= MS_IDLE;
                    end else begin
                        timer <= timer_inc[WIN_W-1:0];
                    end
                end
                default: state <= MS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ring_rng_fingerprint.sv
`timescale 1ns/1ps
// Top of the shared ring oscillator engine. One ring bank feeds both the
// random bit path and the fingerprint path in parallel; the fingerprint
// path routes the two challenged rings to a pair of edge counters. The
// rings themselves are external and arrive on ring_in.
module ring_rng_fingerprint #(
    parameter int N_RING = 32,
    parameter int CODE_W = 5,
    parameter int WIN_W  = 16,
    parameter int CNT_W  = 20,
    localparam int IDX_W = $clog2(N_RING)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_RING-1:0]        ring_in,
    output logic [N_RING-1:0]        ring_en,
    output logic [N_RING*CODE_W-1:0] ring_dly,
    input  logic                     cfg_we,
    input  logic [IDX_W-1:0]         cfg_idx,
    input  logic [CODE_W-1:0]        cfg_code,
    input  logic                     cfg_run,
    input  logic [WIN_W-1:0]         win_len,
    input  logic                     chal_valid,
    input  logic [2*IDX_W-1:0]       chal,
    output logic                     busy,
    output logic                     resp_valid,
    output logic                     resp_bit,
    output logic                     resp_tie,
    output logic                     chal_err,
    output logic                     rnd_bit,
    output logic                     rnd_valid
);

    localparam int N_SIDE = 2;

    logic [IDX_W-1:0] sel [N_SIDE];
    logic [CNT_W-1:0] side_count [N_SIDE];
    logic             clr_req;
    logic             run_req;

    rrf_cfg_bank #(
        .N_RING (N_RING),
        .CODE_W (CODE_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_code  (cfg_code),
        .wr_run   (cfg_run),
        .run_en   (ring_en),
        .dly_code (ring_dly)
    );

    rrf_entropy_path #(
        .N_RING (N_RING)
    ) u_entropy (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_in   (ring_in),
        .run_en    (ring_en),
        .rnd_bit   (rnd_bit),
        .rnd_valid (rnd_valid)
    );

    // One counter per challenged side, clocked by the selected ring.
    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        logic side_clk;
        assign side_clk = ring_in[sel[s]];

        rrf_edge_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .ring_clk (side_clk),
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_req  (clr_req),
            .run_req  (run_req),
            .count    (side_count[s])
        );
    end

    rrf_measure_ctrl #(
        .IDX_W (IDX_W),
        .WIN_W (WIN_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .chal_valid (chal_valid),
        .chal       (chal),
        .win_len    (win_len),
        .count_a    (side_count[0]),
        .count_b    (side_count[1]),
        .sel_a      (sel[0]),
        .sel_b      (sel[1]),
        .clr_req    (clr_req),
        .run_req    (run_req),
        .busy       (busy),
        .resp_valid (resp_valid),
        .resp_bit   (resp_bit),
        .resp_tie   (resp_tie),
        .chal_err   (chal_err)
    );

endmodule

// File: rtl/rrf_checker.sv
`timescale 1ns/1ps
// Protocol checker for ring_rng_fingerprint, attached by bind. Observes
// ports only.
module rrf_checker #(
    parameter int N_RING = 32,
    parameter int CODE_W = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_RING-1:0]        ring_en,
    input logic [N_RING*CODE_W-1:0] ring_dly,
    input logic                     cfg_we,
    input logic                     busy,
    input logic                     resp_valid,
    input logic                     resp_bit,
    input logic                     resp_tie,
    input logic                     chal_err,
    input logic                     rnd_valid
);

    logic ring_any;
    assign ring_any = |ring_en;

    // Configuration holds without a write strobe.
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(ring_dly) && $stable(ring_en)));

    // Valid strobe trails the enables by three edges.
    assert_valid_follows_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_valid == $past(ring_any, 3));

    // A tie never reports a 1.
    assert_tie_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_tie) |-> !resp_bit);

    // A rejected challenge never starts a measurement.
    assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chal_err |-> (!busy && !resp_valid));

    // Response follows the fall of busy.
    assert_resp_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $fell(busy));

    // Response strobe lasts one cycle.
    assert_resp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // Never a response and an error together.
    assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_valid, chal_err}));

endmodule

bind ring_rng_fingerprint rrf_checker #(
    .N_RING (N_RING),
    .CODE_W (CODE_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_en    (ring_en),
    .ring_dly   (ring_dly),
    .cfg_we     (cfg_we),
    .busy       (busy),
    .resp_valid (resp_valid),
    .resp_bit   (resp_bit),
    .resp_tie   (resp_tie),
    .chal_err   (chal_err),
    .rnd_valid  (rnd_valid)
);

// File: tb/tb_ring_rng_fingerprint.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected responses, a monitor pops
// them as the design reports. Rings are behavioural toggling processes or
// static levels.
module tb_ring_rng_fingerprint;

    localparam int N    = 32;
    localparam int CW   = 5;
    localparam int WW   = 16;
    localparam int IW   = 5;
    localparam int WIN  = 40;

    typedef struct {
        bit    is_err;
        bit    rbit;
        bit    tie;
        string req;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    ring_line;
    logic [N-1:0]    ring_en;
    logic [N*CW-1:0] ring_dly;
    logic            cfg_we = 1'b0;
    logic [IW-1:0]   cfg_idx = '0;
    logic [CW-1:0]   cfg_code = '0;
    logic            cfg_run = 1'b0;
    logic [WW-1:0]   win_len = '0;
    logic            chal_valid = 1'b0;
    logic [2*IW-1:0] chal = '0;
    logic            busy, resp_valid, resp_bit, resp_tie, chal_err, rnd_bit, rnd_valid;

    logic            static_mode = 1'b1;
    logic [N-1:0]    static_pat = '0;
    real             half_ns [N];

    int              n_checks = 0;
    int              n_fail = 0;
    exp_t            exp_q [$];

    always #10 clk = ~clk;

    ring_rng_fingerprint dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_in    (ring_line),
        .ring_en    (ring_en),
        .ring_dly   (ring_dly),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_code   (cfg_code),
        .cfg_run    (cfg_run),
        .win_len    (win_len),
        .chal_valid (chal_valid),
        .chal       (chal),
        .busy       (busy),
        .resp_valid (resp_valid),
        .resp_bit   (resp_bit),
        .resp_tie   (resp_tie),
        .chal_err   (chal_err),
        .rnd_bit    (rnd_bit),
        .rnd_valid  (rnd_valid)
    );

    // Behavioural ring models: static level, stopped, or toggling.
    for (genvar gi = 0; gi < N; gi++) begin : g_ring
        logic line_q = 1'b0;
        assign ring_line[gi] = line_q;
        initial begin
            forever begin
                if (static_mode) begin
                    line_q = static_pat[gi];
                    #1;
                end else if (ring_en[gi] !== 1'b1) begin
                    line_q = 1'b0;
                    #1;
                end else begin
                    #0.3;
                    while (!static_mode && ring_en[gi] === 1'b1) begin
                        #(half_ns[gi]);
                        line_q = ~line_q;
                    end
                end
            end
        end
    end

    task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic cfg_write(input int idx, input int code, input bit run);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_idx  = IW'(idx);
        cfg_code = CW'(code);
        cfg_run  = run;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    // Issue one challenge, queue its expected response, time busy.
    task automatic run_measure(input int a, input int b, input bit eb, input bit et,
                               input bit inject, input string req);
        int busy_n = 0;
        bit trng_ok = 1'b1;
        int exp_busy;
        exp_t e;
        exp_busy = ((win_len == 0) ? 1 : int'(win_len)) + 8;
        e.is_err = 1'b0; e.rbit = eb; e.tie = et; e.req = req;
        @(negedge clk);
        exp_q.push_back(e);
        chal       = {IW'(b), IW'(a)};
        chal_valid = 1'b1;
        @(negedge clk);
        chal_valid = 1'b0;
        while (busy) begin
            busy_n++;
            if (!rnd_valid) trng_ok = 1'b0;
            if (inject && busy_n == 10) begin
                chal       = {IW'(a), IW'(b)};
                chal_valid = 1'b1;
            end else begin
                chal_valid = 1'b0;
            end
            @(negedge clk);
        end
        chal_valid = 1'b0;
        check_eq({req, " R8 busy length"}, 64'(busy_n), 64'(exp_busy));
        check_eq("R10 rnd_valid during measurement", 64'(trng_ok), 64'd1);
    endtask

    // Monitor: pop and compare each reported event.
    always @(negedge clk) begin
        if (rst_n && (resp_valid || chal_err)) begin
            if (exp_q.size() == 0) begin
                check_eq("R9 unexpected event", {62'd0, resp_valid, chal_err}, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check_eq({e.req, " event kind"}, 64'(chal_err), 64'(e.is_err));
                if (!e.is_err) begin
                    check_eq({e.req, " resp_bit"}, 64'(resp_bit), 64'(e.rbit));
                    check_eq({e.req, " resp_tie (R6)"}, 64'(resp_tie), 64'(e.tie));
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [N-1:0] pats [8];
        exp_t ee;
        pats = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0003, 32'h8000_0001,
                 32'hFFFF_FFFF, 32'h0000_0100, 32'h7FFF_FFFF, 32'hA5A5_0F0F};
        for (int i = 0; i < N; i++) half_ns[i] = 4.0;
        half_ns[2]  = 3.0;
        half_ns[7]  = 5.0;
        half_ns[10] = 5.0;

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        check_eq("R1 ring_en", 64'(ring_en), 64'd0);
        check_eq("R1 ring_dly", 64'(|ring_dly), 64'd0);
        check_eq("R1 busy", 64'(busy), 64'd0);
        check_eq("R1 resp_valid", 64'(resp_valid), 64'd0);
        check_eq("R1 chal_err", 64'(chal_err), 64'd0);
        check_eq("R1 rnd_valid", 64'(rnd_valid), 64'd0);

        // R2: configuration writes
        cfg_write(3, 'h15, 1'b1);
        check_eq("R2 code ring3", 64'(ring_dly[3*CW +: CW]), 64'h15);
        check_eq("R2 enable ring3", 64'(ring_en), 64'h8);
        check_eq("R2 others untouched", 64'(|(ring_dly & ~({{(N*CW-CW){1'b0}}, {CW{1'b1}}} << (3*CW)))), 64'd0);
        cfg_write(31, 'h1F, 1'b1);
        check_eq("R2 ring3 kept", 64'(ring_dly[3*CW +: CW]), 64'h15);
        check_eq("R2 code ring31", 64'(ring_dly[31*CW +: CW]), 64'h1F);
        cfg_write(3, 'h0A, 1'b0);
        check_eq("R2 rewrite ring3", 64'({ring_en[3], ring_dly[3*CW +: CW]}), 64'h0A);
        repeat (3) @(negedge clk);
        check_eq("R4 valid with ring31 on", 64'(rnd_valid), 64'd1);

        // R3: parity of a shifting static pattern, three edges late
        for (int k = 0; k < 11; k++) begin
            if (k < 8) static_pat = pats[k];
            if (k >= 3) check_eq("R3 rnd_bit parity", 64'(rnd_bit), 64'(^pats[k-3]));
            @(negedge clk);
        end

        cfg_write(31, 'h1F, 1'b0);
        repeat (3) @(negedge clk);
        check_eq("R4 valid with all off", 64'(rnd_valid), 64'd0);

        // Fingerprint measurements
        static_mode = 1'b0;
        cfg_write(2, 1, 1'b1);
        cfg_write(7, 2, 1'b1);
        cfg_write(10, 3, 1'b1);
        repeat (6) @(negedge clk);
        win_len = WW'(WIN);
        run_measure(2, 7, 1'b1, 1'b0, 1'b0, "R5 fast over slow");
        run_measure(7, 2, 1'b0, 1'b0, 1'b0, "R5 slow over fast");
        run_measure(7, 10, 1'b0, 1'b1, 1'b0, "R6 equal rings");
        run_measure(2, 10, 1'b1, 1'b0, 1'b1, "R9 injected challenge");

        // R7: equal indices rejected
        @(negedge clk);
        ee.is_err = 1'b1; ee.rbit = 1'b0; ee.tie = 1'b0; ee.req = "R7 equal indices";
        exp_q.push_back(ee);
        chal       = {IW'(5), IW'(5)};
        chal_valid = 1'b1;
        @(negedge clk);
        chal_valid = 1'b0;
        check_eq("R7 chal_err pulse", 64'(chal_err), 64'd1);
        check_eq("R7 no busy", 64'(busy), 64'd0);
        @(negedge clk);
        check_eq("R7 pulse ends", 64'(chal_err), 64'd0);
        check_eq("R7 still idle", 64'(busy), 64'd0);

        // R8: zero window acts as one cycle
        win_len = '0;
        run_measure(7, 10, 1'b0, 1'b1, 1'b0, "R8 zero window");

        repeat (5) @(negedge clk);
        check_eq("R9 no pending responses", 64'(exp_q.size()), 64'd0);
        summary();
        $finish;
    end

endmodule